// File: doc/BRIEF.md
# SPI Per-Word Select Regenerator

Some SPI masters hold their slave-select low across a whole multi-word frame and send each word as its own burst of SCLK pulses, stopping the clock between words. Some slaves only accept one word per select, so they need the select to go inactive after every word and to fall again before the next. This block sits between the two. It passes SCLK, MOSI and MISO straight through, and drives a new slave-side select that frames each word on its own.

The block brings the master's select and SCLK into the system clock domain. While the upstream select is low, it counts the rising SCLK edges. On the falling SCLK edge that follows the last bit of a word, it releases the downstream select. It then keeps that select high for a programmable gap and lowers it again, ready for the next word, if the upstream select is still low.

A frame that the master ends partway through a word raises a sticky error flag. The system clock must run at least four times faster than SCLK. SPI mode 0 is assumed: SCLK idles low and the sampling edge is the rising edge. After the last word, the master must wait for the downstream release before it raises its own select. Otherwise the block treats the last word as unfinished.

Top module: `spi_word_cs_regen`

## Requirements
- R1: `s_sclk` equals `m_sclk`, `s_mosi` equals `m_mosi` and `m_miso` equals `s_miso` at all times, with no register in the path.
- R2: While `rst_n` is low and right after it rises, `s_cs_n` is 1 and `word_err` is 0.
- R3: When `m_cs_n` falls from idle, `s_cs_n` goes low within 3 system clocks and stays low at least until the first SCLK edge of the word.
- R4: `s_cs_n` stays low through all WORD_LEN (default 16) rising SCLK edges of a word. It goes high within 3 system clocks after the falling SCLK edge that follows the WORD_LEN-th rising edge. No rising SCLK edge reaches the slave while `s_cs_n` is high and `m_cs_n` is low.
- R5: After a word-end release, `s_cs_n` stays high for GAP_CYC (default 4, at least 2) system clocks. It then goes low again if `m_cs_n` is still low, so a frame of N words gives exactly N falling edges on `s_cs_n`.
- R6: Whenever `m_cs_n` is 1, `s_cs_n` is 1 in the same instant, with no clock delay.
- R7: If `m_cs_n` rises while a word has counted at least one but fewer than all of its rising edges, the bit count clears and `word_err` becomes 1. `word_err` then stays 1 until reset. A frame that ends with the count at zero leaves `word_err` unchanged.
- R8: SCLK edges while `m_cs_n` is 1 are ignored. They assert no select, set no error and add nothing to the bit count of the next word.
- R9: The internal bit count never exceeds WORD_LEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cs_n | input | 1 | Frame-level select from the master, active low |
| m_sclk | input | 1 | Serial clock from the master |
| m_mosi | input | 1 | Master data out |
| m_miso | output | 1 | Slave data returned to the master |
| s_cs_n | output | 1 | Regenerated per-word select to the slave, active low |
| s_sclk | output | 1 | Serial clock forwarded to the slave |
| s_mosi | output | 1 | Master data forwarded to the slave |
| s_miso | input | 1 | Slave data out |
| word_err | output | 1 | Sticky flag: the frame ended partway through a word |

## Verification
The bench sends multi-word frames and counts the falling edges on the downstream select. A design that missed the re-assertion would give fewer edges than words. One that released early would let a slave-side SCLK rising edge through while the select is high. The bench checks that the select is still low just before the last falling SCLK edge of a word that follows stray clock pulses outside a frame. A design that counted those pulses would release that word early. A frame that the master cuts off after five bits must set the error flag and keep it set through a later clean frame, and a frame closed at a word boundary must not set it. A design that dropped the combinational release would leave the slave selected for several clocks after the master lets go.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WORD = 2'd1,
        ST_GAP  = 2'd2
    } sel_state_e;
endpackage

// File: rtl/spi_cs_sync.sv
module spi_cs_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    output logic cs_low,
    output logic sclk_rise,
    output logic sclk_fall
);
    typedef struct packed {
        logic sclk_m;
        logic sclk_s;
        logic sclk_p;
        logic cs_m;
        logic cs_s;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.sclk_m = sclk_in;
        r_d.sclk_s = r_q.sclk_m;
        r_d.sclk_p = r_q.sclk_s;
        r_d.cs_m   = cs_n_in;
        r_d.cs_s   = r_q.cs_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sclk_m: 1'b0, sclk_s: 1'b0, sclk_p: 1'b0, cs_m: 1'b1, cs_s: 1'b1};
        else        r_q <= r_d;
    end

    assign cs_low    = ~r_q.cs_s;
    assign sclk_rise =  r_q.sclk_s & ~r_q.sclk_p;
    assign sclk_fall = ~r_q.sclk_s &  r_q.sclk_p;
endmodule

// File: rtl/spi_cs_bitcnt.sv
module spi_cs_bitcnt #(
    parameter int WORD_LEN = 16,
    localparam int CW = $clog2(WORD_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          rise,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en && rise && !full)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign full = (cnt_q == CW'(WORD_LEN));
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/spi_cs_fsm.sv
module spi_cs_fsm
    import spi_cs_pkg::*;
#(
    parameter int GAP_CYC = 4,
    localparam int GW = $clog2(GAP_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_low,
    input  logic sclk_fall,
    input  logic word_full,
    input  logic cnt_zero,
    output logic sel_n,
    output logic cnt_clr,
    output logic cnt_en,
    output logic err
);
    typedef struct packed {
        sel_state_e    state;
        logic [GW-1:0] gap;
        logic          err;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            ST_IDLE: begin
                if (cs_low) f_d.state = ST_WORD;
            end
            ST_WORD: begin
                if (!cs_low) begin
                    if (!cnt_zero) f_d.err = 1'b1;
                    f_d.state = ST_IDLE;
                end else if (word_full && sclk_fall) begin
                    f_d.state = ST_GAP;
                    f_d.gap   = '0;
                end
            end
            ST_GAP: begin
                if (!cs_low)
                    f_d.state = ST_IDLE;
                else if (f_q.gap == GW'(GAP_CYC - 1))
                    f_d.state = ST_WORD;
                else
                    f_d.gap = f_q.gap + 1'b1;
            end
            default: f_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_IDLE, gap: '0, err: 1'b0};
        else        f_q <= f_d;
    end

    assign sel_n   = (f_q.state != ST_WORD);
    assign cnt_en  = (f_q.state == ST_WORD);
    assign cnt_clr = (f_q.state != ST_WORD);
    assign err     = f_q.err;
endmodule

// File: rtl/spi_word_cs_regen.sv
module spi_word_cs_regen #(
    parameter int WORD_LEN = 16,
    parameter int GAP_CYC  = 4,
    localparam int CW = $clog2(WORD_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic m_cs_n,
    input  logic m_sclk,
    input  logic m_mosi,
    output logic m_miso,
    output logic s_cs_n,
    output logic s_sclk,
    output logic s_mosi,
    input  logic s_miso,
    output logic word_err
);
    logic          cs_low, sclk_rise, sclk_fall;
    logic [CW-1:0] bit_cnt;
    logic          word_full, cnt_zero, cnt_clr, cnt_en, fsm_sel_n;

    spi_cs_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (m_sclk),
        .cs_n_in   (m_cs_n),
        .cs_low    (cs_low),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    spi_cs_bitcnt #(.WORD_LEN(WORD_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .rise  (sclk_rise),
        .cnt   (bit_cnt),
        .full  (word_full),
        .zero  (cnt_zero)
    );

    spi_cs_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (cs_low),
        .sclk_fall (sclk_fall),
        .word_full (word_full),
        .cnt_zero  (cnt_zero),
        .sel_n     (fsm_sel_n),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en),
        .err       (word_err)
    );

    assign s_cs_n = fsm_sel_n | m_cs_n;
    assign s_sclk = m_sclk;
    assign s_mosi = m_mosi;
    assign m_miso = s_miso;
endmodule

// File: rtl/spi_word_cs_regen_chk.sv
module spi_word_cs_regen_chk #(
    parameter int WORD_LEN = 16,
    localparam int CW = $clog2(WORD_LEN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_cs_n,
    input logic          s_cs_n,
    input logic          word_err,
    input logic [CW-1:0] bit_cnt
);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_err |=> word_err);

    // R7
    err_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_err) |-> s_cs_n);

    // R5
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_cs_n) && !m_cs_n) |=> s_cs_n);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(WORD_LEN));

    // R2
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (s_cs_n && !word_err));
endmodule

bind spi_word_cs_regen spi_word_cs_regen_chk #(.WORD_LEN(WORD_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_cs_n   (m_cs_n),
    .s_cs_n   (s_cs_n),
    .word_err (word_err),
    .bit_cnt  (bit_cnt)
);

// File: tb/spi_word_cs_regen_bench.sv
`timescale 1ns/1ps
module spi_word_cs_regen_bench;
    localparam int WL   = 16;
    localparam int GAP  = 4;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_cs_n = 1'b1, m_sclk = 1'b0, m_mosi = 1'b0, s_miso = 1'b0;
    logic m_miso, s_cs_n, s_sclk, s_mosi, word_err;

    int checks = 0;
    int errors = 0;
    int sel_falls = 0;
    int hi_run = 0;
    int min_hi = 1000000;
    int bad_edges = 0;
    logic prev_sel = 1'b1;

    always #10 clk = ~clk;

    spi_word_cs_regen u_spi_word_cs_regen (
        .clk(clk), .rst_n(rst_n), .m_cs_n(m_cs_n), .m_sclk(m_sclk), .m_mosi(m_mosi),
        .m_miso(m_miso), .s_cs_n(s_cs_n), .s_sclk(s_sclk), .s_mosi(s_mosi),
        .s_miso(s_miso), .word_err(word_err)
    );

    always @(negedge clk) begin
        if (s_cs_n) hi_run++;
        else begin
            if (prev_sel) begin
                sel_falls++;
                if (hi_run < min_hi) min_hi = hi_run;
            end
            hi_run = 0;
        end
        prev_sel = s_cs_n;
    end

    always @(posedge s_sclk)
        if (s_cs_n && !m_cs_n) bad_edges++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bits(input int n, input bit check_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); m_sclk = 1'b1; m_mosi = i[0];
            repeat (HALF) @(negedge clk);
            // R4: still selected just before the closing falling edge
            if (check_last && i == n - 1) chk(s_cs_n == 1'b0, "R4 low before last fall", s_cs_n, 0);
            m_sclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(s_cs_n == 1'b1, "R2 sel in reset", s_cs_n, 1);
        chk(word_err == 1'b0, "R2 err in reset", word_err, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(s_cs_n == 1'b1, "R2 sel after reset", s_cs_n, 1);
        chk(word_err == 1'b0, "R2 err after reset", word_err, 0);
    endtask

    task automatic t_passthru();
        @(negedge clk); m_sclk = 1'b1; m_mosi = 1'b0; s_miso = 1'b1; #1;
        chk(s_sclk == 1'b1 && s_mosi == 1'b0 && m_miso == 1'b1, "R1 pass A",
            {s_sclk, s_mosi, m_miso}, 3'b101);
        m_sclk = 1'b0; m_mosi = 1'b1; s_miso = 1'b0; #1;
        chk(s_sclk == 1'b0 && s_mosi == 1'b1 && m_miso == 1'b0, "R1 pass B",
            {s_sclk, s_mosi, m_miso}, 3'b010);
        chk(s_cs_n == 1'b1, "R8 passthru sclk no select", s_cs_n, 1);
    endtask

    task automatic t_ignore();
        bit stayed = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); m_sclk = ~m_sclk;
            repeat (HALF) @(negedge clk);
            if (!s_cs_n) stayed = 1'b0;
        end
        m_sclk = 1'b0;
        repeat (4) @(negedge clk);
        chk(stayed, "R8 stray sclk no select", stayed, 1);
        chk(word_err == 1'b0, "R8 stray sclk no error", word_err, 0);
    endtask

    task automatic t_frame(input int nwords, input bit exp_err, input string tag);
        sel_falls = 0; min_hi = 1000000; bad_edges = 0;
        @(negedge clk); m_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        // R3
        chk(s_cs_n == 1'b0, {"R3 select on frame start ", tag}, s_cs_n, 0);
        repeat (4) @(negedge clk);
        for (int w = 0; w < nwords; w++) begin
            send_bits(WL, 1'b1);
            @(negedge clk);
            // R4: released three clocks after the closing fall
            chk(s_cs_n == 1'b1, {"R4 release after word ", tag}, s_cs_n, 1);
            if (w != nwords - 1) begin
                @(negedge clk);
                // R5: gap still held
                chk(s_cs_n == 1'b1, {"R5 gap held ", tag}, s_cs_n, 1);
                repeat (18) @(negedge clk);
                chk(s_cs_n == 1'b0, {"R5 reselect before next word ", tag}, s_cs_n, 0);
            end
        end
        m_cs_n = 1'b1; #1;
        chk(s_cs_n == 1'b1, {"R6 close frame ", tag}, s_cs_n, 1);
        repeat (6) @(negedge clk);
        chk(sel_falls == nwords, {"R5 select edges per word ", tag}, sel_falls, nwords);
        if (nwords > 1) chk(min_hi >= GAP, {"R5 min gap ", tag}, min_hi, GAP);
        chk(bad_edges == 0, {"R4 no sclk while released ", tag}, bad_edges, 0);
        // R7: word-boundary close keeps the flag; R9 exact count seen via R4
        chk(word_err == exp_err, {"R7 err after frame ", tag}, word_err, int'(exp_err));
    endtask

    task automatic t_abort();
        @(negedge clk); m_cs_n = 1'b0;
        repeat (8) @(negedge clk);
        send_bits(5, 1'b0);
        @(negedge clk); m_cs_n = 1'b1; #1;
        // R6
        chk(s_cs_n == 1'b1, "R6 immediate release on abort", s_cs_n, 1);
        repeat (5) @(negedge clk);
        // R7
        chk(word_err == 1'b1, "R7 err on partial word", word_err, 1);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_passthru();
        t_frame(3, 1'b0, "three");
        t_ignore();
        t_frame(1, 1'b0, "after stray");
        t_abort();
        t_frame(2, 1'b1, "after abort");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule